// File: doc/BRIEF.md
# Fast Oscillator Startup Stabilization Timer

This block decides when a fast oscillator may run and measures how long it has been running since its last start. The system uses the result to decide whether the fast clock is stable enough to take over from the slow secondary clock. A 13-bit count chain advances once per qualified fast-oscillator edge while the oscillator is running. The chain is built from a 7-bit low divider feeding a 6-bit high counter. A carry out of the high counter raises the stable flag.

The chain is reloaded in one of two ways, and the choice depends on how the oscillator was last stopped. Clearing the enable bit loads the chain with the value 0x078. A restart then takes exactly 8072 ticks. Entering stop mode with the enable bit still set clears only the high counter and leaves the low divider unchanged, so the restart takes between 8065 and 8192 ticks. Stop mode halts execution. A wake interrupt resumes execution at once on the slow clock, and it restarts the oscillator only if the enable bit is set.

Top module: `fosc_stab_timer`

## Requirements
- R1: After reset, `stable` and `halted` are 0 and the chain holds 0. With `osc_en` at 1, `stable` rises after exactly 8192 counted ticks.
- R2: The chain is a 7-bit low divider that carries into a 6-bit high counter. `stable` becomes 1 on the clock edge that applies the tick which carries out of the 6-bit high counter.
- R3: A tick is counted only on a clock edge where `fast_tick` is 1 and `osc_run` is 1. Idle cycles between ticks do not change the number of ticks needed.
- R4: While `osc_en` is 0, `osc_run` is 0, `stable` is cleared, and the chain is held at 0x078. When `osc_en` returns to 1, `stable` rises after exactly 8072 ticks.
- R5: A `stop_req` with `osc_en` at 1 sets `halted`, clears `stable` and the high counter, and keeps the low divider value L. After `wake_irq`, `stable` rises after 8192 − L ticks.
- R6: A `stop_req` with `osc_en` at 0 sets `halted` and the chain is loaded with 0x078. `wake_irq` leaves `osc_run` at 0. Setting `osc_en` then gives `stable` after 8072 ticks.
- R7: While `halted` is 1, `osc_run` is 0 and ticks are not counted. `wake_irq` clears `halted` on the next edge, whatever the state of `stable`.
- R8: Once `stable` is 1, further ticks leave it at 1 until `osc_en` goes low or stop mode is entered.
- R9: A `stop_req` while already halted has no effect. A `wake_irq` while not halted does not change `halted` or the tick count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | Fast oscillator enable bit |
| stop_req | input | 1 | Stop-mode entry request (one-cycle pulse) |
| wake_irq | input | 1 | External wake interrupt |
| fast_tick | input | 1 | Qualified fast-oscillator edge |
| osc_run | output | 1 | Fast oscillator run enable |
| stable | output | 1 | Fast oscillator stable flag |
| halted | output | 1 | Execution halted in stop mode |

## Verification
Each kind of restart is measured by counting ticks until `stable` rises. The cases are power-up, re-enable after `osc_en` was cleared, and wake after stop with the enable bit set or clear. Together they separate a full clear, a 0x078 preset and a kept low divider. The stop-with-enable case is swept over several residual divider values, including 127 and a value whose carry had already reached the high counter, so that an off-by-one in either stage shows up. Ticks are also applied with idle gaps, with stray wake pulses, and while halted or disabled, so that counting of unqualified edges shows up as a changed total.

// File: rtl/fosc_stab_timer.sv
module fosc_stab_timer #(
  parameter int LO_W   = 7,
  parameter int HI_W   = 6,
  parameter int PRESET = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic stop_req,
  input  logic wake_irq,
  input  logic fast_tick,
  output logic osc_run,
  output logic stable,
  output logic halted
);
  localparam int CW = LO_W + HI_W;
  localparam logic [CW-1:0] PRE = CW'(PRESET);

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            stable_q, halted_q;

  wire stop_go = stop_req & ~halted_q;
  wire wake_go = wake_irq & halted_q;
  wire lo_cy   = &lo_q;
  wire hi_cy   = &hi_q;

  assign osc_run = osc_en & ~halted_q;
  wire advance = osc_run & fast_tick & ~stable_q & ~stop_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
    end else if (stop_go) begin
      halted_q <= 1'b1;
    end else if (wake_go) begin
      halted_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      stable_q <= 1'b0;
    end else if (!osc_en) begin
      {hi_q, lo_q} <= PRE;
      stable_q     <= 1'b0;
    end else if (stop_go) begin
      hi_q     <= '0;
      stable_q <= 1'b0;
    end else if (advance) begin
      lo_q <= lo_q + 1'b1;
      if (lo_cy) hi_q <= hi_q + 1'b1;
      if (lo_cy && hi_cy) stable_q <= 1'b1;
    end
  end

  assign stable = stable_q;
  assign halted = halted_q;
endmodule

module fosc_stab_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic stop_req,
  input logic wake_irq,
  input logic fast_tick,
  input logic osc_run,
  input logic stable,
  input logic halted
);
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    osc_run |-> osc_en); // R4
  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !stable); // R4
  AST_HALT_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !osc_run); // R7
  AST_STOP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !halted) |=> (halted && !stable)); // R5
  AST_WAKE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake_irq) |=> !halted); // R7
  AST_STOP_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wake_irq) |=> halted); // R9
  AST_WAKE_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !stop_req) |=> !halted); // R9
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stable) |-> $past(fast_tick && osc_run)); // R3
  AST_STABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stable && osc_en && !(stop_req && !halted)) |=> stable); // R8
endmodule

bind fosc_stab_timer fosc_stab_timer_chk i_chk (.*);

// File: tb/test_fosc_stab_timer.sv
module test_fosc_stab_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_en = 1'b1, stop_req = 1'b0, wake_irq = 1'b0, fast_tick = 1'b0;
  logic osc_run, stable, halted;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fosc_stab_timer i_fosc_stab_timer (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int period, input int wake_at, output int n);
    int c = 0;
    n = 0;
    while (!stable && n < 9000) begin
      fast_tick = (c % period == 0);
      wake_irq  = (c == wake_at);
      @(negedge clk);
      if (fast_tick) n++;
      c++;
    end
    fast_tick = 1'b0;
    wake_irq  = 1'b0;
  endtask

  task automatic ticks(input int k);
    fast_tick = 1'b1;
    idle(k);
    fast_tick = 1'b0;
  endtask

  task automatic restart_preset;
    osc_en = 1'b0;
    idle(2);
    osc_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_stop;
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
  endtask

  task automatic pulse_wake;
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
  endtask

  initial begin
    int n, k, lo, exp;
    int ks[4] = '{0, 7, 100, 8};
    idle(3);
    chk(stable == 0 && halted == 0 && osc_run == 1, "R1 reset state", {stable, halted, osc_run}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    measure(1, -1, n);
    chk(n == 8192, "R1 R2 power-up ticks", n, 8192);

    ticks(50);
    chk(stable == 1 && osc_run == 1, "R8 stable holds", stable, 1);

    osc_en = 1'b0;
    idle(1);
    chk(stable == 0 && osc_run == 0, "R4 enable low clears", {stable, osc_run}, 0);
    ticks(300);
    chk(stable == 0, "R4 no count while off", stable, 0);
    osc_en = 1'b1;
    @(negedge clk);
    measure(3, 40, n);
    chk(n == 8072, "R3 R4 R9 gapped re-enable ticks", n, 8072);
    chk(halted == 0, "R9 wake when not halted", halted, 0);

    foreach (ks[i]) begin
      k = ks[i];
      restart_preset();
      ticks(k);
      lo  = (120 + k) % 128;
      exp = 8192 - lo;
      pulse_stop();
      chk(halted == 1 && stable == 0 && osc_run == 0, "R5 stop entry", {halted, stable, osc_run}, 4);
      ticks(20);
      pulse_stop();
      chk(halted == 1, "R7 R9 halted ignores ticks and stop", halted, 1);
      pulse_wake();
      chk(halted == 0 && osc_run == 1, "R7 wake resumes", {halted, osc_run}, 1);
      measure(1, -1, n);
      chk(n == exp, "R5 ticks after stop with enable", n, exp);
    end

    osc_en = 1'b0;
    @(negedge clk);
    pulse_stop();
    chk(halted == 1 && stable == 0, "R6 stop with enable low", {halted, stable}, 2);
    pulse_wake();
    chk(halted == 0 && osc_run == 0, "R6 wake keeps oscillator off", {halted, osc_run}, 0);
    ticks(200);
    chk(stable == 0, "R6 no stable while off", stable, 0);
    osc_en = 1'b1;
    @(negedge clk);
    chk(osc_run == 1, "R6 enable restarts", osc_run, 1);
    measure(2, -1, n);
    chk(n == 8072, "R6 ticks after enable", n, 8072);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule